// File: doc/BRIEF.md
# Zoned External Bus Interface Controller

This block turns single accesses from an on-chip requester into strobed cycles on an external asynchronous memory bus. A request carries an address, write data, a direction flag and a three-bit zone number. The zone number selects one of three shared active-low chip selects. It also selects a per-zone timing entry that holds a lead count, an active count and a trail count. The controller raises the chip select for the lead phase and then asserts the read or write strobe for the active phase. The active phase is stretched while the external ready input is low. The chip select is then held through the trail phase before the bus returns to idle.

Zone 7 can be reached only when a configuration bit is set. That bit is loaded from a strap input while reset is held, and configuration writes can change it afterwards. An external master can take the bus by pulling a hold request low. The controller grants only when no access is running and none is waiting. While the grant lasts it drops every output enable and holds off the internal requester. Tri-state behaviour is modelled with separate enable outputs for the address group, the write-data group and the control group.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Zones 0 and 1 drive `ext_cs01_n` low, zone 2 drives `ext_cs2_n` low, and zone 6 drives `ext_cs67_n` low. Zone 7 also drives `ext_cs67_n` low, but only when the zone-7 enable bit is 1. No more than one chip select is low at any time.
- R2: In a mapped access, the chip select is low for exactly L cycles before the strobe, the strobe is low for A cycles, and the chip select stays low for exactly T cycles after the strobe. L, A and T come from the timing entry of the addressed zone, which `cfg_we` writes. A field value of zero counts as one cycle, and the largest value is 15.
- R3: A read asserts only `ext_rd_n` and a write asserts only `ext_we_n`. The two strobes are never low together.
- R4: `ext_rnw` is high while the bus is idle and during reads. It is low for every cycle in which the chip select of a write is low.
- R5: When `cfg_rdy_async` is 0, the active phase ends only at a clock edge where `ext_ready` is high, once the programmed active count has elapsed. Each extra cycle with ready low adds one cycle of strobe.
- R6: When `cfg_rdy_async` is 1, ready passes through a two-stage synchronizer and the active phase is two cycles longer than programmed. A late ready adds the two cycles of synchronizer latency after ready rises.
- R7: A mapped read produces one `rsp_valid` pulse during the first trail cycle. `rsp_rdata` carries the value on `ext_rdata` in the last active cycle. Writes produce no response.
- R8: Requests to zones 3, 4 and 5, and to zone 7 while its enable bit is 0, are accepted without any chip select or strobe. A read among them returns `rsp_valid` with data zero in the cycle after acceptance.
- R9: The zone-7 enable bit takes the value of `strap_mode` while `rst_n` is low. Changes on `strap_mode` after reset have no effect. `cfg_mode_we` overwrites the bit with `cfg_mode_val`.
- R10: A low `bus_hold_n` seen while idle with no request pending sets `bus_holda_n` low one cycle later. During the grant, all three enables and `req_ready` are low and requests are not issued. A request pending alongside the hold, and an access in progress, complete before the grant.
- R11: When `bus_hold_n` returns high, `bus_holda_n` goes high one cycle later and requests are served again.
- R12: `ext_data_oe` is high only while a write has its chip select low. `ext_addr_oe` and `ext_ctl_oe` are high whenever the bus is not granted away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mode | input | 1 | Zone-7 enable strap, sampled only during reset |
| cfg_we | input | 1 | Write strobe for a zone timing entry |
| cfg_zone | input | 3 | Zone whose timing entry is written |
| cfg_lead | input | 4 | Lead cycle count |
| cfg_active | input | 4 | Active cycle count |
| cfg_trail | input | 4 | Trail cycle count |
| cfg_mode_we | input | 1 | Overwrite strobe for the zone-7 enable bit |
| cfg_mode_val | input | 1 | New value of the zone-7 enable bit |
| cfg_rdy_async | input | 1 | 1 selects the synchronized ready path |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_zone | input | 3 | Target zone |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| bus_hold_n | input | 1 | Active-low bus hold request |
| bus_holda_n | output | 1 | Active-low hold acknowledge |
| ext_cs01_n | output | 1 | Chip select for zones 0 and 1 |
| ext_cs2_n | output | 1 | Chip select for zone 2 |
| ext_cs67_n | output | 1 | Chip select for zones 6 and 7 |
| ext_rd_n | output | 1 | Read strobe |
| ext_we_n | output | 1 | Write strobe |
| ext_rnw | output | 1 | High for read, low for write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | High when the peripheral can finish |
| ext_addr_oe | output | 1 | Address group drive enable |
| ext_data_oe | output | 1 | Write-data group drive enable |
| ext_ctl_oe | output | 1 | Strobe and chip-select group drive enable |

## Verification
The bench builds the controller with its default parameters: 16-bit address and data, 4-bit phase counts, eight zones and a two-stage ready synchronizer. With 4-bit counts the bench can program the largest phase length of 15 cycles and the zero setting on the same build. The two-stage synchronizer lets it check the fixed two-cycle extension of the asynchronous ready path against the synchronous path. Eight zones give the bench the three unmapped zones and the strap-gated zone 7.

// File: rtl/ebc_pkg.sv
// Shared definitions for the external bus controller.
// Assumes a single clock domain for every sub-block.
package ebc_pkg;

    // Sequencer states; HOLD means the bus is granted to an outside master.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACTIVE,
        ST_TRAIL,
        ST_HOLD
    } ebc_state_t;

    // Bit positions of the chip-select groups in a one-hot select vector.
    localparam int CSG_Z01 = 0;
    localparam int CSG_Z2  = 1;
    localparam int CSG_Z67 = 2;
    localparam int CSG_N   = 3;

endpackage

// File: rtl/ebc_zone_cfg.sv
// Per-zone phase timing storage plus the zone-7 enable bit.
// The timing entries are written one zone at a time, and reading is combinational by zone.
// The enable bit follows the strap only while reset is held.
module ebc_zone_cfg #(
    parameter int NZ      = 8,
    parameter int CW      = 4,
    parameter int DEF_CNT = 1,
    parameter int ZW      = $clog2(NZ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_mode,
    input  logic          wr_en,
    input  logic [ZW-1:0] wr_zone,
    input  logic [CW-1:0] wr_lead,
    input  logic [CW-1:0] wr_act,
    input  logic [CW-1:0] wr_trail,
    input  logic          mode_we,
    input  logic          mode_val,
    input  logic [ZW-1:0] rd_zone,
    output logic [CW-1:0] rd_lead,
    output logic [CW-1:0] rd_act,
    output logic [CW-1:0] rd_trail,
    output logic          mode_bit
);
    localparam int            TW    = 3 * CW;
    localparam logic [CW-1:0] DEF_V = CW'(DEF_CNT);

    logic [TW-1:0] tim_all [NZ];
    logic [TW-1:0] rd_sel;

    for (genvar g = 0; g < NZ; g++) begin : g_zone
        logic [TW-1:0] tim_q;
        // Hold the lead/active/trail counts of this zone.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim_q <= {DEF_V, DEF_V, DEF_V};
            else if (wr_en && (wr_zone == ZW'(g)))
                tim_q <= {wr_lead, wr_act, wr_trail};
        end
        assign tim_all[g] = tim_q;
    end

    // Look up the entry of the requested zone.
    always_comb begin
        rd_sel   = tim_all[rd_zone];
        rd_lead  = rd_sel[TW-1 -: CW];
        rd_act   = rd_sel[2*CW-1 -: CW];
        rd_trail = rd_sel[CW-1:0];
    end

    // Strap capture during reset, software overwrite afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_bit <= strap_mode;
        else if (mode_we)
            mode_bit <= mode_val;
    end

    // R9
    strap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_bit));

endmodule

// File: rtl/ebc_zone_map.sv
// Zone decoder: maps a zone number to a one-hot chip-select group.
// Zones without a group, and zone 7 while disabled, report a miss.
module ebc_zone_map #(
    parameter int ZW = 3
) (
    input  logic                     zone,
    input  logic [ZW-1:0]            zone_num,
    input  logic                     z7_en,
    output logic [ebc_pkg::CSG_N-1:0] cs_sel,
    output logic                     hit
);
    import ebc_pkg::*;

    // Decode the zone number into a group select.
    always_comb begin
        cs_sel = '0;
        case (zone_num)
            ZW'(0), ZW'(1): cs_sel[CSG_Z01] = zone;
            ZW'(2):         cs_sel[CSG_Z2]  = zone;
            ZW'(6):         cs_sel[CSG_Z67] = zone;
            ZW'(7):         cs_sel[CSG_Z67] = zone & z7_en;
            default:        cs_sel = '0;
        endcase
        hit = |cs_sel;
    end

endmodule

// File: rtl/ebc_rdy_sync.sv
// Multi-stage synchronizer for the external ready input.
// Assumes STAGES >= 1; the output lags the input by STAGES clocks.
module ebc_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    if (STAGES > 1) begin : g_chain
        // Shift the input through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], din};
        end
    end else begin : g_single
        // Single flop stage.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= din;
        end
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/ebc_seq.sv
// Access sequencer: accepts one request at a time and walks it through
// the lead, active and trail phases. It stretches the active phase with ready and
// arbitrates bus hold. Timing is latched at acceptance, so later
// configuration writes do not disturb an access in flight.
module ebc_seq #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int CW     = 4,
    parameter int STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [AW-1:0]             req_addr,
    input  logic [DW-1:0]             req_wdata,
    input  logic [CW-1:0]             t_lead,
    input  logic [CW-1:0]             t_act,
    input  logic [CW-1:0]             t_trail,
    input  logic                      map_hit,
    input  logic [ebc_pkg::CSG_N-1:0] map_cs,
    input  logic                      rdy_async,
    input  logic                      rdy_direct,
    input  logic                      rdy_synced,
    output logic                      rsp_valid,
    output logic [DW-1:0]             rsp_rdata,
    input  logic                      bus_hold_n,
    output logic                      bus_holda_n,
    output logic [ebc_pkg::CSG_N-1:0] cs_n,
    output logic                      rd_n,
    output logic                      we_n,
    output logic                      rnw,
    output logic [AW-1:0]             addr,
    output logic [DW-1:0]             wdata,
    input  logic [DW-1:0]             rdata,
    output logic                      addr_oe,
    output logic                      data_oe,
    output logic                      ctl_oe
);
    import ebc_pkg::*;

    localparam int NW = $clog2((1 << CW) + STAGES + 1);

    ebc_state_t          state;
    logic [NW-1:0]       cnt;
    logic [AW-1:0]       addr_q;
    logic [DW-1:0]       wdata_q;
    logic                wr_q;
    logic                async_q;
    logic [CSG_N-1:0]    cs_q;
    logic [CW-1:0]       act_q;
    logic [CW-1:0]       trail_q;
    logic                busy;
    logic                rdy_sel;

    // Effective phase length: a zero setting behaves as one cycle.
    function automatic logic [NW-1:0] eff(input logic [CW-1:0] v);
        eff = (v == '0) ? NW'(1) : NW'(v);
    endfunction

    assign rdy_sel = async_q ? rdy_synced : rdy_direct;

    // Phase sequencing, request capture and read data return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            wr_q      <= 1'b0;
            async_q   <= 1'b0;
            cs_q      <= '0;
            act_q     <= '0;
            trail_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        wr_q    <= req_write;
                        async_q <= rdy_async;
                        cs_q    <= map_cs;
                        act_q   <= t_act;
                        trail_q <= t_trail;
                        if (map_hit) begin
                            state <= ST_LEAD;
                            cnt   <= eff(t_lead) - NW'(1);
                        end else if (!req_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= '0;
                        end
                    end else if (!bus_hold_n) begin
                        state <= ST_HOLD;
                    end
                end
                ST_LEAD: begin
                    if (cnt == '0) begin
                        state <= ST_ACTIVE;
                        cnt   <= eff(act_q) - NW'(1) + (async_q ? NW'(STAGES) : NW'(0));
                    end else begin
                        cnt <= cnt - NW'(1);
                    end
                end
                ST_ACTIVE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - NW'(1);
                    end else if (rdy_sel) begin
                        if (!wr_q) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rdata;
                        end
                        state <= ST_TRAIL;
                        cnt   <= eff(trail_q) - NW'(1);
                    end
                end
                ST_TRAIL: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - NW'(1);
                end
                ST_HOLD: begin
                    if (bus_hold_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive bus pins and enables from the phase state.
    always_comb begin
        busy        = (state == ST_LEAD) || (state == ST_ACTIVE) || (state == ST_TRAIL);
        cs_n        = busy ? ~cs_q : '1;
        rd_n        = !((state == ST_ACTIVE) && !wr_q);
        we_n        = !((state == ST_ACTIVE) && wr_q);
        rnw         = !(busy && wr_q);
        addr        = addr_q;
        wdata       = wdata_q;
        addr_oe     = (state != ST_HOLD);
        ctl_oe      = (state != ST_HOLD);
        data_oe     = busy && wr_q;
        req_ready   = (state == ST_IDLE);
        bus_holda_n = (state != ST_HOLD);
    end

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n));

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !we_n) |-> (cs_n != '1));

    // R4
    rnw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !rnw);

    // R10
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_holda_n) |-> ($past(!bus_hold_n) && $past(cs_n == '1) && $past(!req_valid)));

    // R10
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_holda_n |-> (!ctl_oe && !addr_oe && !data_oe && !req_ready));

    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_holda_n && bus_hold_n) |=> bus_holda_n);

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/ext_bus_ctrl.sv
// Top level of the zoned external bus controller. It connects the timing
// store, the zone decoder, the ready synchronizer and the sequencer.
// Assumes bus_hold_n is already synchronous to clk.
module ext_bus_ctrl #(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 4,
    parameter int NZ          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_CNT     = 1,
    parameter int ZW          = $clog2(NZ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_mode,
    input  logic          cfg_we,
    input  logic [ZW-1:0] cfg_zone,
    input  logic [CW-1:0] cfg_lead,
    input  logic [CW-1:0] cfg_active,
    input  logic [CW-1:0] cfg_trail,
    input  logic          cfg_mode_we,
    input  logic          cfg_mode_val,
    input  logic          cfg_rdy_async,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [ZW-1:0] req_zone,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          bus_hold_n,
    output logic          bus_holda_n,
    output logic          ext_cs01_n,
    output logic          ext_cs2_n,
    output logic          ext_cs67_n,
    output logic          ext_rd_n,
    output logic          ext_we_n,
    output logic          ext_rnw,
    output logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ext_wdata,
    input  logic [DW-1:0] ext_rdata,
    input  logic          ext_ready,
    output logic          ext_addr_oe,
    output logic          ext_data_oe,
    output logic          ext_ctl_oe
);
    import ebc_pkg::*;

    logic [CW-1:0]    t_lead, t_act, t_trail;
    logic             z7_en;
    logic [CSG_N-1:0] map_cs;
    logic             map_hit;
    logic             rdy_synced;
    logic [CSG_N-1:0] cs_n;

    ebc_zone_cfg #(.NZ(NZ), .CW(CW), .DEF_CNT(DEF_CNT), .ZW(ZW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode),
        .wr_en(cfg_we), .wr_zone(cfg_zone), .wr_lead(cfg_lead),
        .wr_act(cfg_active), .wr_trail(cfg_trail),
        .mode_we(cfg_mode_we), .mode_val(cfg_mode_val),
        .rd_zone(req_zone), .rd_lead(t_lead), .rd_act(t_act),
        .rd_trail(t_trail), .mode_bit(z7_en)
    );

    ebc_zone_map #(.ZW(ZW)) u_map (
        .zone(1'b1), .zone_num(req_zone), .z7_en(z7_en),
        .cs_sel(map_cs), .hit(map_hit)
    );

    ebc_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk(clk), .rst_n(rst_n), .din(ext_ready), .dout(rdy_synced)
    );

    ebc_seq #(.AW(AW), .DW(DW), .CW(CW), .STAGES(SYNC_STAGES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .t_lead(t_lead), .t_act(t_act), .t_trail(t_trail),
        .map_hit(map_hit), .map_cs(map_cs), .rdy_async(cfg_rdy_async),
        .rdy_direct(ext_ready), .rdy_synced(rdy_synced),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_hold_n(bus_hold_n), .bus_holda_n(bus_holda_n),
        .cs_n(cs_n), .rd_n(ext_rd_n), .we_n(ext_we_n), .rnw(ext_rnw),
        .addr(ext_addr), .wdata(ext_wdata), .rdata(ext_rdata),
        .addr_oe(ext_addr_oe), .data_oe(ext_data_oe), .ctl_oe(ext_ctl_oe)
    );

    assign ext_cs01_n = cs_n[CSG_Z01];
    assign ext_cs2_n  = cs_n[CSG_Z2];
    assign ext_cs67_n = cs_n[CSG_Z67];

endmodule

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_mode = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_zone = '0;
    logic [3:0]  cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
    logic        cfg_mode_we = 1'b0, cfg_mode_val = 1'b0, cfg_rdy_async = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [2:0]  req_zone = '0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        bus_hold_n = 1'b1, bus_holda_n;
    logic        ext_cs01_n, ext_cs2_n, ext_cs67_n, ext_rd_n, ext_we_n, ext_rnw;
    logic [15:0] ext_addr, ext_wdata, ext_rdata;
    logic        ext_ready = 1'b1;
    logic        ext_addr_oe, ext_data_oe, ext_ctl_oe;

    int checks = 0;
    int errors = 0;

    // Stimulus vectors: [31:29] zone, [28] write, [27:24] lead, [23:20] active, [19:16] trail, [15:0] data
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 1'b0, 4'd1,  4'd1,  4'd1,  16'h1111},
        {3'd1, 1'b1, 4'd2,  4'd3,  4'd1,  16'hBEEF},
        {3'd2, 1'b0, 4'd3,  4'd2,  4'd4,  16'h0000},
        {3'd6, 1'b1, 4'd0,  4'd0,  4'd0,  16'hCAFE},
        {3'd7, 1'b0, 4'd15, 4'd15, 4'd15, 16'h0000},
        {3'd2, 1'b1, 4'd4,  4'd1,  4'd2,  16'h5555},
        {3'd3, 1'b0, 4'd2,  4'd2,  4'd2,  16'h0000},
        {3'd5, 1'b1, 4'd2,  4'd2,  4'd2,  16'h7777},
        {3'd0, 1'b1, 4'd1,  4'd5,  4'd3,  16'hA5A5},
        {3'd6, 1'b0, 4'd2,  4'd2,  4'd2,  16'h0000}
    };

    ext_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode),
        .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_lead(cfg_lead),
        .cfg_active(cfg_active), .cfg_trail(cfg_trail),
        .cfg_mode_we(cfg_mode_we), .cfg_mode_val(cfg_mode_val),
        .cfg_rdy_async(cfg_rdy_async),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_zone(req_zone), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_hold_n(bus_hold_n), .bus_holda_n(bus_holda_n),
        .ext_cs01_n(ext_cs01_n), .ext_cs2_n(ext_cs2_n), .ext_cs67_n(ext_cs67_n),
        .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n), .ext_rnw(ext_rnw),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_ready(ext_ready), .ext_addr_oe(ext_addr_oe),
        .ext_data_oe(ext_data_oe), .ext_ctl_oe(ext_ctl_oe)
    );

    // Memory model: read data derived from the address.
    assign ext_rdata = ext_addr ^ 16'h5A5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Measurements from one access.
    int          m_lead, m_act, m_trail, m_nrsp;
    int          bad_rnw, bad_oe, bad_hold, bad_strobe;
    logic [2:0]  m_mask;
    logic [15:0] m_rdata;
    logic        m_idle_rnw;
    int          rel_at = 0;
    logic        hold_with_req = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        strap_mode = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic prog_zone(input logic [2:0] z, input logic [3:0] l, input logic [3:0] a, input logic [3:0] t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_zone = z; cfg_lead = l; cfg_active = a; cfg_trail = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and measure the bus waveform at negedges until idle.
    task automatic run_access(input logic [2:0] z, input logic w, input logic [15:0] a, input logic [15:0] d);
        logic seen;
        logic csl;
        seen = 1'b0;
        m_lead = 0; m_act = 0; m_trail = 0; m_nrsp = 0; m_mask = '0; m_rdata = '0;
        bad_rnw = 0; bad_oe = 0; bad_hold = 0; bad_strobe = 0; m_idle_rnw = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_zone = z; req_write = w; req_addr = a; req_wdata = d;
        if (hold_with_req) bus_hold_n = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 400; k++) begin
            csl = !(ext_cs01_n && ext_cs2_n && ext_cs67_n);
            if (csl) begin
                seen = 1'b1;
                m_mask = m_mask | ~{ext_cs67_n, ext_cs2_n, ext_cs01_n};
                if (!ext_rd_n || !ext_we_n) m_act++;
                else if (m_act == 0)       m_lead++;
                else                       m_trail++;
                if (ext_rnw != !w)      bad_rnw++;
                if (ext_data_oe != w)   bad_oe++;
                if (!bus_holda_n)       bad_hold++;
            end
            if (!ext_rd_n && !ext_we_n) bad_strobe++;
            if ((!ext_rd_n && w) || (!ext_we_n && !w)) bad_strobe++;
            if (rsp_valid) begin
                m_nrsp++;
                m_rdata = rsp_rdata;
            end
            if ((!ext_rd_n || !ext_we_n) && rel_at > 0 && m_act == rel_at) ext_ready = 1'b1;
            if (seen && !csl) begin
                m_idle_rnw = ext_rnw;
                break;
            end
            if (!seen && k >= 4) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [2:0] exp_mask(input logic [2:0] z, input logic z7);
        case (z)
            3'd0, 3'd1: exp_mask = 3'b001;
            3'd2:       exp_mask = 3'b010;
            3'd6:       exp_mask = 3'b100;
            3'd7:       exp_mask = z7 ? 3'b100 : 3'b000;
            default:    exp_mask = 3'b000;
        endcase
    endfunction

    function automatic int effc(input logic [3:0] v);
        effc = (v == 4'd0) ? 1 : int'(v);
    endfunction

    // Check the measurements of a completed access against expectations.
    task automatic check_access(input logic [2:0] z, input logic w, input logic [15:0] a,
                                input int el, input int ea, input int et, input logic z7);
        logic [2:0] em;
        em = exp_mask(z, z7);
        chk("R1", "chip select group", int'(m_mask), int'(em));
        if (em != 3'b000) begin
            chk("R2", "lead cycles", m_lead, el);
            chk("R2", "active cycles", m_act, ea);
            chk("R2", "trail cycles", m_trail, et);
            chk("R7", "response count", m_nrsp, w ? 0 : 1);
            if (!w) chk("R7", "read data", int'(m_rdata), int'(a ^ 16'h5A5A));
        end else begin
            chk("R8", "strobe cycles on unmapped zone", m_act + m_lead, 0);
            chk("R8", "response count", m_nrsp, w ? 0 : 1);
            if (!w) chk("R8", "read data zero", int'(m_rdata), 0);
        end
        chk("R3", "strobe exclusivity", bad_strobe, 0);
        chk("R4", "rnw during access", bad_rnw, 0);
        chk("R4", "rnw idle high", int'(m_idle_rnw), 1);
        chk("R12", "data enable during access", bad_oe, 0);
        chk("R10", "no grant during access", bad_hold, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        @(negedge clk);
        // Reset state.
        chk("R10", "reset holda", int'(bus_holda_n), 1);
        chk("R1", "reset chip selects", int'({ext_cs67_n, ext_cs2_n, ext_cs01_n}), 7);
        chk("R3", "reset strobes", int'({ext_rd_n, ext_we_n}), 3);
        chk("R4", "reset rnw", int'(ext_rnw), 1);
        chk("R12", "reset enables", int'({ext_addr_oe, ext_ctl_oe, ext_data_oe}), 3'b110);
        chk("R7", "reset rsp_valid", int'(rsp_valid), 0);
        chk("R11", "reset req_ready", int'(req_ready), 1);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  z;
            logic        w;
            logic [15:0] a;
            z = VEC[i][31:29];
            w = VEC[i][28];
            a = 16'h0100 + 16'(i * 16'h0111);
            prog_zone(z, VEC[i][27:24], VEC[i][23:20], VEC[i][19:16]);
            run_access(z, w, a, VEC[i][15:0]);
            check_access(z, w, a, effc(VEC[i][27:24]), effc(VEC[i][23:20]),
                         effc(VEC[i][19:16]), 1'b1);
        end

        // R5: synchronous ready held low past the active count.
        prog_zone(3'd2, 4'd1, 4'd2, 4'd1);
        ext_ready = 1'b0; rel_at = 5;
        run_access(3'd2, 1'b0, 16'h0222, 16'h0);
        chk("R5", "sync ready stretched active", m_act, 5);
        chk("R5", "read data after wait", int'(m_rdata), int'(16'h0222 ^ 16'h5A5A));
        rel_at = 0; ext_ready = 1'b1;

        // R6: asynchronous ready, ready already high.
        @(negedge clk); cfg_rdy_async = 1'b1;
        prog_zone(3'd1, 4'd1, 4'd3, 4'd1);
        run_access(3'd1, 1'b1, 16'h0333, 16'h1234);
        chk("R6", "async active extension", m_act, 5);
        chk("R6", "async lead unchanged", m_lead, 1);

        // R6: asynchronous ready released late.
        ext_ready = 1'b0; rel_at = 6;
        run_access(3'd1, 1'b0, 16'h0444, 16'h0);
        chk("R6", "async late ready", m_act, 8);
        rel_at = 0; ext_ready = 1'b1;
        @(negedge clk); cfg_rdy_async = 1'b0;

        // R10 / R11: grant while idle.
        @(negedge clk); bus_hold_n = 1'b0;
        @(negedge clk);
        chk("R10", "holda after idle hold", int'(bus_holda_n), 0);
        chk("R10", "enables floated", int'({ext_addr_oe, ext_ctl_oe, ext_data_oe}), 0);
        chk("R10", "req_ready low in grant", int'(req_ready), 0);
        req_valid = 1'b1; req_zone = 3'd0; req_write = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "no access while granted", int'({ext_cs67_n, ext_cs2_n, ext_cs01_n}), 7);
        req_valid = 1'b0;
        bus_hold_n = 1'b1;
        @(negedge clk);
        chk("R11", "holda released", int'(bus_holda_n), 1);
        chk("R11", "enables restored", int'({ext_addr_oe, ext_ctl_oe}), 3);

        // R10: hold arriving with a pending request waits for the access.
        prog_zone(3'd0, 4'd2, 4'd2, 4'd2);
        hold_with_req = 1'b1;
        run_access(3'd0, 1'b1, 16'h0555, 16'h4321);
        hold_with_req = 1'b0;
        chk("R10", "pending access completed first", m_act, 2);
        chk("R10", "no grant during pending access", bad_hold, 0);
        @(negedge clk);
        chk("R10", "grant after access", int'(bus_holda_n), 0);
        bus_hold_n = 1'b1;
        @(negedge clk);
        chk("R11", "release after pending grant", int'(bus_holda_n), 1);

        // R9: strap low at reset disables zone 7.
        do_reset(1'b0);
        run_access(3'd7, 1'b0, 16'h0777, 16'h0);
        chk("R9", "zone 7 blocked by strap", int'(m_mask), 0);
        chk("R8", "blocked zone 7 read response", m_nrsp, 1);
        run_access(3'd6, 1'b0, 16'h0666, 16'h0);
        chk("R1", "zone 6 unaffected by strap", int'(m_mask), 3'b100);
        @(negedge clk); strap_mode = 1'b1;
        run_access(3'd7, 1'b0, 16'h0778, 16'h0);
        chk("R9", "strap ignored after reset", int'(m_mask), 0);
        @(negedge clk); cfg_mode_we = 1'b1; cfg_mode_val = 1'b1;
        @(negedge clk); cfg_mode_we = 1'b0;
        run_access(3'd7, 1'b0, 16'h0779, 16'h0);
        chk("R9", "software enables zone 7", int'(m_mask), 3'b100);
        chk("R7", "zone 7 read data", int'(m_rdata), int'(16'h0779 ^ 16'h5A5A));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule